// File: doc/BRIEF.md
# Audio Clock-Regeneration Packet Scheduler

This block decides on which cycles an audio clock-regeneration packet is requested on an HDMI-style link, and it supplies the 20-bit CTS value that packet carries. A register-style configuration port sets a transmit mode and an alternation ratio. Level inputs provide the programmed CTS, a replacement low byte and a per-blanking repeat count. The link scheduler grants a packet slot with `slot_ok`. A packet counts as sent on every clock edge where `pkt_req` and `slot_ok` are both high.

The transmit modes are as follows. Mode 0 is silent. Mode 1 sends one packet and then returns to mode 0 by itself. Mode 2 sends a fixed number of packets after each rising edge of the vertical-blanking input. Mode 3 sends a packet each time a pixel-tick counter reaches the programmed CTS. Mode 4 forwards externally measured CTS values. Outside mode 4, the CTS carried by each packet alternates between the full programmed value and a variant whose low byte is replaced, in a ratio set by a 2-bit field.

Top module: `acr_sched`

## Requirements
- R1: After reset, `mode_rd` reads 000 and `pkt_req` is low.
- R2: The primary CTS is `cts_prog[19:0]`. The secondary CTS is `{cts_prog[19:8], cts_lo_alt[7:0]}`.
- R3: For ratio code k (`cfg_ratio`), code 0 carries only the primary value. For k = 1, 2 and 3, the block sends k primary packets, then one secondary packet, and repeats that pattern.
- R4: Mode 000 (and the unused codes 101 to 111) produces no request, whatever happens on `vblank`, `pix_tick`, `meas_vld` and `slot_ok`.
- R5: Mode 001 sends exactly one packet. Mode 001 stays in effect until that packet is sent. After that, `mode_rd` reads 000.
- R6: Mode 010 loads `rep_cnt` pending packets on each rising edge of `vblank`. Packets still unsent at the next rising edge are discarded, not added to the new count.
- R7: In mode 011, each `pix_tick` increments a counter. When the counter reaches `cts_prog`, it restarts at zero and one packet is requested.
- R8: In mode 011 with `cts_prog` equal to 0, no packet is requested.
- R9: In mode 100, each `meas_vld` pulse requests one packet carrying the `meas_cts` value captured with that pulse. The ratio field has no effect in this mode.
- R10: The alternation position moves only when a packet is sent. Every `cfg_wr` returns it to the first primary slot.
- R11: An asserted request stays high, with its CTS unchanged, until a slot is granted. In mode 010, a rising edge of `vblank` may also reload the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for mode and ratio |
| cfg_mode | input | 3 | Transmit mode written on `cfg_wr` |
| cfg_ratio | input | 2 | Alternation ratio written on `cfg_wr` |
| cts_prog | input | 20 | Programmed CTS |
| cts_lo_alt | input | 8 | Low byte of the secondary CTS |
| rep_cnt | input | 4 | Packets per blanking interval in mode 010 |
| vblank | input | 1 | Vertical-blanking level |
| pix_tick | input | 1 | One pulse per pixel clock |
| meas_vld | input | 1 | Strobe for a new measured CTS |
| meas_cts | input | 20 | Measured CTS value |
| slot_ok | input | 1 | Packet slot granted this cycle |
| pkt_req | output | 1 | Packet requested |
| pkt_cts | output | 20 | CTS for the requested packet |
| mode_rd | output | 3 | Current mode, showing the one-shot self-clear |

## Verification
An alternation position that drifts shows up on the very next granted packet, because `pkt_cts` then carries the wrong low byte. The scoreboard compares every sent packet in order, so such an error cannot hide. A wrong pending count or pixel counter shows up as a missing or extra packet within one blanking interval or one CTS period. A one-shot mode that fails to clear shows up on `mode_rd` one cycle after the grant, and as a second packet on the following cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [2:0] {
    M_OFF  = 3'd0,
    M_ONCE = 3'd1,
    M_VBI  = 3'd2,
    M_PIX  = 3'd3,
    M_MEAS = 3'd4
  } acr_mode_e;
endpackage

// File: rtl/acr_trigger.sv
module acr_trigger
  import acr_pkg::*;
#(
  parameter int CTS_W = 20,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [2:0]       mode,
  input  logic             sent,
  input  logic             vblank,
  input  logic             pix_tick,
  input  logic             meas_vld,
  input  logic [CTS_W-1:0] meas_cts,
  input  logic [CTS_W-1:0] cts_prog,
  input  logic [REP_W-1:0] rep_cnt,
  output logic             req_nxt,
  output logic [CTS_W-1:0] meas_nxt
);
  localparam logic [CTS_W-1:0] ONE = CTS_W'(1);

  logic             vb_q, vb_rise;
  logic [REP_W-1:0] cnt_q, cnt_d;
  logic [CTS_W-1:0] pcnt_q, pcnt_d, meas_q;
  logic             pend_q, pend_d;

  always_comb begin
    vb_rise  = vblank & ~vb_q;
    cnt_d    = cnt_q;
    pcnt_d   = pcnt_q;
    pend_d   = pend_q;
    meas_nxt = meas_q;
    if (clr) begin
      cnt_d  = '0;
      pcnt_d = '0;
      pend_d = 1'b0;
    end else begin
      case (mode)
        M_VBI: begin
          if (vb_rise)                    cnt_d = rep_cnt;
          else if (sent && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        end
        M_PIX: begin
          pend_d = pend_q & ~sent;
          if (pix_tick && cts_prog != '0) begin
            if (pcnt_q + ONE == cts_prog) begin
              pcnt_d = '0;
              pend_d = 1'b1;
            end else begin
              pcnt_d = pcnt_q + ONE;
            end
          end
        end
        M_MEAS: begin
          pend_d = pend_q & ~sent;
          if (meas_vld) begin
            pend_d   = 1'b1;
            meas_nxt = meas_cts;
          end
        end
        default: ;
      endcase
    end
    case (mode)
      M_ONCE:         req_nxt = 1'b1;
      M_VBI:          req_nxt = (cnt_d != '0);
      M_PIX, M_MEAS:  req_nxt = pend_d;
      default:        req_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_q   <= 1'b0;
      cnt_q  <= '0;
      pcnt_q <= '0;
      pend_q <= 1'b0;
      meas_q <= '0;
    end else begin
      vb_q   <= vblank;
      cnt_q  <= cnt_d;
      pcnt_q <= pcnt_d;
      pend_q <= pend_d;
      meas_q <= meas_nxt;
    end
  end

  // R6: a grant in blanking mode with no reload consumes exactly one credit
  a_r6_credit_consumed: assert property (@(posedge clk) disable iff (rst)
    (mode == M_VBI && !clr && !vb_rise && sent && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R8: zero CTS leaves the pixel counter idle
  a_r8_zero_cts_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PIX && !clr && cts_prog == '0) |=> $stable(pcnt_q));
endmodule

// File: rtl/acr_cts_sel.sv
module acr_cts_sel #(
  parameter int CTS_W = 20,
  parameter int LO_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [1:0]       ratio,
  input  logic             advance,
  input  logic [CTS_W-1:0] cts_prog,
  input  logic [LO_W-1:0]  lo_alt,
  output logic [CTS_W-1:0] cts_nxt
);
  logic [1:0] ph_q, ph_d;

  always_comb begin
    if (clr)          ph_d = 2'd0;
    else if (advance) ph_d = (ph_q >= ratio) ? 2'd0 : ph_q + 2'd1;
    else              ph_d = ph_q;
    if (ratio != 2'd0 && ph_d == ratio)
      cts_nxt = {cts_prog[CTS_W-1:LO_W], lo_alt};
    else
      cts_nxt = cts_prog;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 2'd0;
    else     ph_q <= ph_d;
  end

  // R3: the position never runs past the secondary slot of the pattern
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
    !clr |-> ph_q <= ratio);

  // R10: without a grant or a write the position holds
  a_r10_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !advance) |=> $stable(ph_q));
endmodule

// File: rtl/acr_sched.sv
module acr_sched
  import acr_pkg::*;
#(
  parameter int CTS_W = 20,
  parameter int LO_W  = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_ratio,
  input  logic [CTS_W-1:0] cts_prog,
  input  logic [LO_W-1:0]  cts_lo_alt,
  input  logic [REP_W-1:0] rep_cnt,
  input  logic             vblank,
  input  logic             pix_tick,
  input  logic             meas_vld,
  input  logic [CTS_W-1:0] meas_cts,
  input  logic             slot_ok,
  output logic             pkt_req,
  output logic [CTS_W-1:0] pkt_cts,
  output logic [2:0]       mode_rd
);
  logic [2:0]       mode_q, mode_d;
  logic [1:0]       ratio_q, ratio_d;
  logic             sent, req_nxt;
  logic [CTS_W-1:0] meas_nxt, alt_nxt;

  assign sent    = pkt_req & slot_ok;
  assign mode_rd = mode_q;

  always_comb begin
    ratio_d = cfg_wr ? cfg_ratio : ratio_q;
    if (cfg_wr)                        mode_d = cfg_mode;
    else if (sent && mode_q == M_ONCE) mode_d = M_OFF;
    else                               mode_d = mode_q;
  end

  acr_trigger #(.CTS_W(CTS_W), .REP_W(REP_W)) u_trig (
    .clk(clk), .rst(rst), .clr(cfg_wr), .mode(mode_d), .sent(sent),
    .vblank(vblank), .pix_tick(pix_tick), .meas_vld(meas_vld),
    .meas_cts(meas_cts), .cts_prog(cts_prog), .rep_cnt(rep_cnt),
    .req_nxt(req_nxt), .meas_nxt(meas_nxt)
  );

  acr_cts_sel #(.CTS_W(CTS_W), .LO_W(LO_W)) u_sel (
    .clk(clk), .rst(rst), .clr(cfg_wr), .ratio(ratio_d),
    .advance(sent && mode_q != M_MEAS), .cts_prog(cts_prog),
    .lo_alt(cts_lo_alt), .cts_nxt(alt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_OFF;
      ratio_q <= 2'd0;
      pkt_req <= 1'b0;
      pkt_cts <= '0;
    end else begin
      mode_q  <= mode_d;
      ratio_q <= ratio_d;
      pkt_req <= req_nxt;
      pkt_cts <= (mode_d == M_MEAS) ? meas_nxt : alt_nxt;
    end
  end

  // R5: a granted one-shot returns the mode to off and drops the request
  a_r5_oneshot_clears: assert property (@(posedge clk) disable iff (rst)
    (sent && mode_q == M_ONCE && !cfg_wr) |=> (mode_rd == M_OFF && !pkt_req));

  // R4: the off mode never shows a request
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_OFF) |-> !pkt_req);

  // R11: an ungranted request persists
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (pkt_req && !slot_ok && !cfg_wr && !vblank) |=> pkt_req);
endmodule

// File: tb/tb_acr_sched.sv
`timescale 1ns/1ps
module tb_acr_sched;
  logic        clk = 0, rst = 1;
  logic        cfg_wr = 0;
  logic [2:0]  cfg_mode = 0;
  logic [1:0]  cfg_ratio = 0;
  logic [19:0] cts_prog = 20'hABCDE;
  logic [7:0]  cts_lo_alt = 8'h11;
  logic [3:0]  rep_cnt = 0;
  logic        vblank = 0, pix_tick = 0, meas_vld = 0, slot_ok = 0;
  logic [19:0] meas_cts = 0;
  logic        pkt_req;
  logic [19:0] pkt_cts;
  logic [2:0]  mode_rd;

  localparam logic [19:0] VA = 20'hABCDE;
  localparam logic [19:0] VB = 20'hABC11;

  int n_run = 0, n_fail = 0, n_sent = 0, base;
  int bph = 0, brat = 0;
  logic [19:0] expq[$];

  always #2.5 clk = ~clk;

  acr_sched dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [2:0] m, input logic [1:0] r);
    cfg_mode = m; cfg_ratio = r; cfg_wr = 1;
    tick(1);
    cfg_wr = 0; bph = 0; brat = r;
  endtask

  task automatic push_ab(input int n);
    for (int i = 0; i < n; i++) begin
      expq.push_back((brat != 0 && bph == brat) ? VB : VA);
      bph = (bph >= brat) ? 0 : bph + 1;
    end
  endtask

  task automatic vb_pulse();
    vblank = 1; tick(1); vblank = 0; tick(1);
  endtask

  task automatic q_empty(input string tag);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  // monitor: pops one expected CTS for every granted request
  always @(negedge clk) begin
    if (!rst && pkt_req && slot_ok) begin
      n_sent++;
      if (expq.size() == 0) chk(0, "R3/R4 unexpected packet", pkt_cts, 0);
      else begin
        automatic logic [19:0] e = expq.pop_front();
        chk(pkt_cts == e, "R2/R3/R9 packet CTS", pkt_cts, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk(mode_rd == 3'd0, "R1 reset mode", mode_rd, 0);
    chk(pkt_req == 1'b0, "R1 reset req", pkt_req, 0);

    // R4: off mode ignores every stimulus
    base = n_sent;
    cfg(3'd0, 2'd1);
    rep_cnt = 4'd3; slot_ok = 1; pix_tick = 1; meas_vld = 1; cts_prog = 20'd2;
    vb_pulse(); tick(18);
    pix_tick = 0; meas_vld = 0; cts_prog = VA; slot_ok = 0;
    chk(n_sent == base, "R4 off sends nothing", n_sent - base, 0);

    // R5: one-shot
    base = n_sent;
    slot_ok = 1;
    cfg(3'd1, 2'd1); push_ab(1);
    tick(5);
    chk(n_sent - base == 1, "R5 one packet", n_sent - base, 1);
    chk(mode_rd == 3'd0, "R5 mode self-clears", mode_rd, 0);
    q_empty("R5 queue");

    // R6/R11/R3: blanking mode, ratio 1:1
    slot_ok = 0; rep_cnt = 4'd3;
    cfg(3'd2, 2'd1);
    vb_pulse(); tick(4);
    chk(pkt_req == 1'b1, "R11 request held without slot", pkt_req, 1);
    push_ab(3); slot_ok = 1; tick(10); slot_ok = 0;
    q_empty("R6 three per interval");
    vb_pulse();
    push_ab(1); slot_ok = 1; tick(1); slot_ok = 0; tick(3);
    q_empty("R11 single grant");
    base = n_sent;
    vb_pulse();
    push_ab(3); slot_ok = 1; tick(10); slot_ok = 0;
    chk(n_sent - base == 3, "R6 unsent dropped at reload", n_sent - base, 3);
    q_empty("R6 queue");

    // R10: rewrite restarts alternation on the primary value
    cfg(3'd2, 2'd1); rep_cnt = 4'd1;
    vb_pulse(); push_ab(1); slot_ok = 1; tick(6); slot_ok = 0;
    q_empty("R10 restart at primary");

    // R3: ratio 0 always primary, ratio 3 pattern
    cfg(3'd2, 2'd0); rep_cnt = 4'd4;
    vb_pulse(); push_ab(4); slot_ok = 1; tick(12); slot_ok = 0;
    q_empty("R3 ratio 0");
    cfg(3'd2, 2'd3); rep_cnt = 4'd5;
    vb_pulse(); push_ab(5); slot_ok = 1; tick(14); slot_ok = 0;
    q_empty("R3 ratio 3");

    // R7: pixel counting, ratio 2:1
    base = n_sent;
    cts_prog = 20'd5; slot_ok = 1;
    cfg(3'd3, 2'd2);
    for (int i = 0; i < 4; i++) begin
      expq.push_back((bph == 2) ? {20'd5 & 20'hFFF00} | 20'h11 : 20'd5);
      bph = (bph >= 2) ? 0 : bph + 1;
    end
    pix_tick = 1; tick(20); pix_tick = 0; tick(8);
    chk(n_sent - base == 4, "R7 one packet per CTS ticks", n_sent - base, 4);
    q_empty("R7 queue");

    // R8: zero CTS in pixel mode
    base = n_sent;
    cts_prog = 20'd0;
    cfg(3'd3, 2'd0);
    pix_tick = 1; tick(30); pix_tick = 0; tick(4);
    chk(n_sent == base, "R8 zero CTS silent", n_sent - base, 0);
    cts_prog = VA;

    // R9: measured mode ignores ratio
    cfg(3'd4, 2'd3); slot_ok = 1;
    meas_cts = 20'h12345; expq.push_back(20'h12345);
    meas_vld = 1; tick(1); meas_vld = 0; tick(4);
    meas_cts = 20'h0F0F0; expq.push_back(20'h0F0F0);
    meas_vld = 1; tick(1); meas_vld = 0; tick(4);
    q_empty("R9 measured values");

    tick(5);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule